// File: doc/BRIEF.md
# Keyed-restart watchdog timer

This block is a memory-mapped watchdog for a system-on-chip. Software programs a timeout as a 4-bit interval code. The code selects one entry from a fixed, non-linear table of half-second multiples, from 0.5 s up to 16 s. The countdown advances only when the `tick` input strobes, so the same block can serve any timebase. The parameter `HALF_TICKS` sets how many ticks make half a second.

To keep the system alive, software must write a control word that carries the restart bit and a 12-bit key before the count runs out. A control write that lacks the correct key is ignored.

On expiry, a configuration field chooses the action:
- a reset pulse of fixed length on `sys_rst_o`, or
- a sticky pending flag that drives `irq_o` through a mask bit.

After either action the count stops until software re-arms it.

Top module: `wdog_keyed`

## Requirements
- R1: After reset, every readable register reads zero and both `irq_o` and `sys_rst_o` are low.
- R2: Interval codes 0 to 11 select 1, 2, 4, 6, 8, 10, 12, 16, 20, 24, 28 and 32 half-seconds, in that order. The period in ticks is the half-second count times `HALF_TICKS`.
- R3: Once the counter is loaded with period P, expiry happens on the P-th tick after the load. After expiry the counter stays stopped.
- R4: A write to offset 0x10 with bit 0 set and bits 12:1 equal to 0xA57 is a keyed restart. While the block is enabled, a keyed restart reloads the full period, so repeated restarts at shorter spacing prevent expiry.
- R5: A write to offset 0x10 is ignored and the count runs on unchanged in either case:
  - the key bits differ from 0xA57, or
  - bit 0 is clear.
- R6: When the action field (offset 0x14, bits 1:0) is 2, expiry sets the pending flag (offset 0x04, bit 0) and does not pulse `sys_rst_o`.
- R7: `irq_o` equals the pending flag ANDed with the enable bit (offset 0x00, bit 0). Writing 1 to offset 0x04 bit 0 clears the pending flag. Writing 0 there leaves it set.
- R8: When the action field is 1, expiry drives `sys_rst_o` high for exactly `RST_PULSE` clocks. It leaves the pending flag clear, and no later pulse follows unless software re-arms the block.
- R9: Reserved interval codes 12 to 15 behave as the 32 half-second maximum.
- R10: The mode register is at offset 0x18, with bit 0 as enable and bits 7:4 as the interval code. Writing it with bit 0 clear stops the count without any expiry. A keyed restart while disabled is ignored.
- R11: Writing the mode register with bit 0 set reloads the counter with the newly written interval, even while a count is running.
- R12: The counter advances only on clocks where `tick` is high.
- R13: Register reads return the following values:
  - mode reads as {code in 7:4, enable in 0};
  - the action field and the interrupt enable read back as written;
  - offset 0x10 reads as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timebase strobe; one count step per high clock |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| sys_rst_o | output | 1 | System reset pulse on expiry |
| irq_o | output | 1 | Masked timeout interrupt |

## Verification
The assertions take two things for granted:
- each write strobe lasts exactly one clock with stable address and data;
- `tick` is a plain level sampled at the clock edge, so a restart or mode write in the same cycle as a tick is resolved by the block's own priority, not by input timing.

The stimulus only writes through a one-cycle write task. It changes `tick` only between edges. It never issues a mode write and a control write in the same cycle. It also clears the pending flag before each run whose expiry cycle is predicted.

// File: rtl/wdog_keyed.sv
module wdog_keyed #(
  parameter int          HALF_TICKS  = 500,
  parameter int          RST_PULSE   = 16,
  parameter int          ADDR_W      = 8,
  parameter logic [11:0] RESTART_KEY = 12'hA57
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              sys_rst_o,
  output logic              irq_o
);

  localparam int CNT_W = $clog2(32 * HALF_TICKS + 1);
  localparam int PLS_W = $clog2(RST_PULSE + 1);

  localparam logic [ADDR_W-1:0] OFS_IRQEN = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] OFS_STAT  = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] OFS_CTRL  = ADDR_W'(8'h10);
  localparam logic [ADDR_W-1:0] OFS_CFG   = ADDR_W'(8'h14);
  localparam logic [ADDR_W-1:0] OFS_MODE  = ADDR_W'(8'h18);

  localparam logic [1:0] ACT_RESET = 2'd1;
  localparam logic [1:0] ACT_IRQ   = 2'd2;

  function automatic logic [CNT_W-1:0] period_ticks(input logic [3:0] code);
    logic [5:0] halves;
    case (code)
      4'd0:    halves = 6'd1;
      4'd1:    halves = 6'd2;
      4'd2:    halves = 6'd4;
      4'd3:    halves = 6'd6;
      4'd4:    halves = 6'd8;
      4'd5:    halves = 6'd10;
      4'd6:    halves = 6'd12;
      4'd7:    halves = 6'd16;
      4'd8:    halves = 6'd20;
      4'd9:    halves = 6'd24;
      4'd10:   halves = 6'd28;
      default: halves = 6'd32;
    endcase
    return CNT_W'(halves) * CNT_W'(HALF_TICKS);
  endfunction

  logic             irq_en;
  logic             pending;
  logic [1:0]       act_sel;
  logic             mode_en;
  logic [3:0]       mode_code;
  logic             armed;
  logic [CNT_W-1:0] cnt;
  logic [PLS_W-1:0] rst_cnt;

  logic wr_irqen, wr_stat, wr_ctrl, wr_cfg, wr_mode;
  logic restart_ok, expire;
  logic unused_wbits;

  assign wr_irqen = bus_we && (bus_addr == OFS_IRQEN);
  assign wr_stat  = bus_we && (bus_addr == OFS_STAT);
  assign wr_ctrl  = bus_we && (bus_addr == OFS_CTRL);
  assign wr_cfg   = bus_we && (bus_addr == OFS_CFG);
  assign wr_mode  = bus_we && (bus_addr == OFS_MODE);

  assign restart_ok = wr_ctrl && bus_wdata[0] && (bus_wdata[12:1] == RESTART_KEY) && mode_en;
  assign expire     = !wr_mode && !restart_ok && armed && tick && (cnt == CNT_W'(1));

  assign unused_wbits = ^bus_wdata[31:13];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_en    <= 1'b0;
      act_sel   <= 2'd0;
      mode_en   <= 1'b0;
      mode_code <= 4'd0;
    end else begin
      if (wr_irqen) irq_en <= bus_wdata[0];
      if (wr_cfg)   act_sel <= bus_wdata[1:0];
      if (wr_mode) begin
        mode_en   <= bus_wdata[0];
        mode_code <= bus_wdata[7:4];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed <= 1'b0;
      cnt   <= '0;
    end else if (wr_mode) begin
      armed <= bus_wdata[0];
      if (bus_wdata[0]) cnt <= period_ticks(bus_wdata[7:4]);
    end else if (restart_ok) begin
      armed <= 1'b1;
      cnt   <= period_ticks(mode_code);
    end else if (armed && tick) begin
      if (cnt == CNT_W'(1)) begin
        armed <= 1'b0;
        cnt   <= '0;
      end else begin
        cnt <= cnt - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pending <= 1'b0;
    else if (expire && act_sel == ACT_IRQ) pending <= 1'b1;
    else if (wr_stat && bus_wdata[0]) pending <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rst_cnt <= '0;
    else if (expire && act_sel == ACT_RESET) rst_cnt <= PLS_W'(RST_PULSE);
    else if (rst_cnt != '0) rst_cnt <= rst_cnt - PLS_W'(1);
  end

  assign sys_rst_o = (rst_cnt != '0);
  assign irq_o     = pending && irq_en;

  always_comb begin
    bus_rdata = 32'd0;
    case (bus_addr)
      OFS_IRQEN: bus_rdata[0]   = irq_en;
      OFS_STAT:  bus_rdata[0]   = pending;
      OFS_CFG:   bus_rdata[1:0] = act_sel;
      OFS_MODE:  bus_rdata[7:0] = {mode_code, 3'b000, mode_en};
      default:   bus_rdata = 32'd0;
    endcase
  end

endmodule

// File: rtl/wdog_keyed_chk.sv
module wdog_keyed_chk #(
  parameter int          ADDR_W      = 8,
  parameter int          CNT_W       = 14,
  parameter int          RST_PULSE   = 16,
  parameter logic [11:0] RESTART_KEY = 12'hA57
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [12:0]       wdata_lo,
  input logic              sys_rst_o,
  input logic              irq_o,
  input logic              armed,
  input logic [CNT_W-1:0]  cnt,
  input logic              pending,
  input logic              mode_en,
  input logic              expire
);

  logic [15:0] hi_len;

  always_ff @(posedge clk) begin
    if (!rst_n) hi_len <= 16'd0;
    else if (sys_rst_o) hi_len <= hi_len + 16'd1;
    else hi_len <= 16'd0;
  end

  logic ctrl_wr, mode_wr, stat_wr;
  assign ctrl_wr = bus_we && (bus_addr == ADDR_W'(8'h10));
  assign mode_wr = bus_we && (bus_addr == ADDR_W'(8'h18));
  assign stat_wr = bus_we && (bus_addr == ADDR_W'(8'h04));

  assert_pulse_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sys_rst_o) |-> hi_len == 16'(RST_PULSE));

  assert_w1c_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && wdata_lo[0] && !expire) |=> !irq_o);

  assert_badkey_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && wdata_lo[0] && wdata_lo[12:1] != RESTART_KEY && !tick) |=> $stable(cnt));

  assert_restart_arms_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && wdata_lo[0] && wdata_lo[12:1] == RESTART_KEY && mode_en) |=> armed);

  assert_expire_from_armed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pending) |-> $past(armed));

  assert_single_action_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_o) |-> !$rose(pending));

  assert_disarm_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr && !wdata_lo[0]) |=> !armed);

endmodule

bind wdog_keyed wdog_keyed_chk #(
  .ADDR_W(ADDR_W), .CNT_W(CNT_W), .RST_PULSE(RST_PULSE), .RESTART_KEY(RESTART_KEY)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .bus_we(bus_we), .bus_addr(bus_addr),
  .wdata_lo(bus_wdata[12:0]), .sys_rst_o(sys_rst_o), .irq_o(irq_o), .armed(armed),
  .cnt(cnt), .pending(pending), .mode_en(mode_en), .expire(expire)
);

// File: tb/tb_wdog_keyed.sv
module tb_wdog_keyed;
  localparam int HALF  = 2;
  localparam int PULSE = 16;
  localparam logic [31:0] GOOD = (32'hA57 << 1) | 32'd1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b1;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = 8'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic        sys_rst_o, irq_o;

  wdog_keyed #(.HALF_TICKS(HALF), .RST_PULSE(PULSE)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sys_rst_o(sys_rst_o), .irq_o(irq_o)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int          at;
    int          kind;
    int          req;
    logic [31:0] exp;
  } item_t;

  item_t sb[$];
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  task automatic expect_at(input int at, input int kind, input int req, input logic [31:0] v);
    item_t it;
    it.at = at; it.kind = kind; it.req = req; it.exp = v;
    sb.push_back(it);
  endtask

  always @(negedge clk) begin
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].at == cyc) begin
        logic [31:0] act;
        act = (sb[i].kind == 0) ? {31'd0, irq_o} :
              (sb[i].kind == 1) ? {31'd0, sys_rst_o} : bus_rdata;
        n_chk++;
        if (act !== sb[i].exp) begin
          n_bad++;
          $display("FAIL R%0d cycle %0d kind %0d: actual %h expected %h",
                   sb[i].req, cyc, sb[i].kind, act, sb[i].exp);
        end
        sb.delete(i);
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_we = 1'b0; bus_wdata = 32'd0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input int req);
    @(posedge clk); #1;
    bus_addr = a;
    expect_at(cyc, 2, req, e);
  endtask

  function automatic int halves(input int code);
    int t[12] = '{1, 2, 4, 6, 8, 10, 12, 16, 20, 24, 28, 32};
    return (code < 12) ? t[code] : 32;
  endfunction

  // wrong-key / no-restart write must not move the expiry (R5)
  task automatic ignored_ctrl(input logic [31:0] d);
    int c;
    wr(8'h04, 32'd1);
    wr(8'h18, 32'h11);
    c = cyc;
    wr(8'h10, d);
    expect_at(c + 3, 0, 5, 0);
    expect_at(c + 4, 0, 5, 1);
    idle(4);
  endtask

  initial begin
    int c;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset values
    rd(8'h00, 0, 1); rd(8'h04, 0, 1); rd(8'h14, 0, 1); rd(8'h18, 0, 1);
    expect_at(cyc, 0, 1, 0);
    expect_at(cyc, 1, 1, 0);

    // R6 / R3 interrupt action, shortest period
    wr(8'h00, 1); wr(8'h14, 2); wr(8'h18, 32'h01);
    c = cyc;
    expect_at(c + 1, 0, 3, 0);
    expect_at(c + 2, 0, 6, 1);
    expect_at(c + 2, 1, 6, 0);
    idle(3);
    rd(8'h04, 1, 6);

    // R7 mask and write-one-to-clear
    wr(8'h00, 0); expect_at(cyc, 0, 7, 0);
    rd(8'h04, 1, 7);
    wr(8'h00, 1); expect_at(cyc, 0, 7, 1);
    wr(8'h04, 0); rd(8'h04, 1, 7);
    wr(8'h04, 1); expect_at(cyc, 0, 7, 0);
    rd(8'h04, 0, 7);
    // R3 counter stays stopped after expiry
    idle(10); expect_at(cyc, 0, 3, 0);

    // R4 keyed restarts keep it alive
    wr(8'h18, 32'h11);
    for (int k = 0; k < 5; k++) begin
      idle(1);
      wr(8'h10, GOOD);
      expect_at(cyc, 0, 4, 0);
    end
    c = cyc;
    expect_at(c + 3, 0, 4, 0);
    expect_at(c + 4, 0, 4, 1);
    idle(5);

    // R5 ignored control writes
    ignored_ctrl((32'hA56 << 1) | 32'd1);
    ignored_ctrl(32'hA57 << 1);

    // R2 / R9 interval table sweep
    for (int code = 0; code < 16; code++) begin
      int t;
      t = halves(code) * HALF;
      wr(8'h04, 1);
      wr(8'h18, (code << 4) | 1);
      c = cyc;
      expect_at(c + t - 1, 0, (code < 12) ? 2 : 9, 0);
      expect_at(c + t, 0, (code < 12) ? 2 : 9, 1);
      idle(t + 1);
    end

    // R11 rewrite while running reloads
    wr(8'h04, 1);
    wr(8'h18, 32'hB1);
    idle(2);
    wr(8'h18, 32'h01);
    c = cyc;
    expect_at(c + 1, 0, 11, 0);
    expect_at(c + 2, 0, 11, 1);
    idle(3);

    // R10 disarm and restart while disabled
    wr(8'h04, 1);
    wr(8'h18, 32'h11);
    wr(8'h18, 32'h00);
    idle(10); expect_at(cyc, 0, 10, 0);
    wr(8'h10, GOOD);
    idle(10); expect_at(cyc, 0, 10, 0);
    rd(8'h04, 0, 10);

    // R12 tick gating
    @(posedge clk); #1 tick = 1'b0;
    wr(8'h18, 32'h01);
    idle(10); expect_at(cyc, 0, 12, 0);
    @(posedge clk); #1 tick = 1'b1;
    c = cyc;
    expect_at(c + 1, 0, 12, 0);
    expect_at(c + 2, 0, 12, 1);
    idle(3);

    // R8 reset action
    wr(8'h04, 1);
    wr(8'h14, 1);
    wr(8'h18, 32'h01);
    c = cyc;
    expect_at(c + 1, 1, 8, 0);
    expect_at(c + 2, 1, 8, 1);
    expect_at(c + 1 + PULSE, 1, 8, 1);
    expect_at(c + 2 + PULSE, 1, 8, 0);
    expect_at(c + 2, 0, 8, 0);
    expect_at(c + 30, 0, 8, 0);
    expect_at(c + 40, 1, 8, 0);
    idle(42);
    rd(8'h04, 0, 8);

    // R13 readback
    wr(8'h18, 32'hF5);
    rd(8'h18, 32'hF1, 13);
    wr(8'h14, 32'hFFFF_FFFF);
    rd(8'h14, 3, 13);
    rd(8'h10, 0, 13);
    rd(8'h00, 1, 13);

    while (sb.size() != 0) @(negedge clk);
    #1;
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule